// File: doc/BRIEF.md
# Associative Memory Road Finder

The block is a content-addressable bank of coarse track patterns. Each stored pattern holds one coarse-bin word for every detector layer. During detector readout, hit words stream in one per cycle on a shared data bus. A plane-select code names the layer each hit belongs to. Every pattern compares the hit against its own word for that layer in the same cycle. On a match it sets a sticky flag for that layer. Flags build up over many cycles, so a pattern collects its layers one hit at a time.

When the event ends, the patterns that have enough matched layers are frozen into a report set. An end-of-event command does this freeze. The report set is read out one pattern address at a time, lowest index first. A pop command drops the address currently shown. A done flag rises once nothing is left to report. A clear command starts a new event by wiping all match flags and any pending report. The stored patterns are not affected.

The bank is loaded through a write operation that addresses one pattern and one layer. The same addressing reads stored words back. The match requirement is normally a programmable layer count. A relaxed mode instead accepts a pattern when its last layer matched and at least four of the five silicon layers matched.

Top module: `assoc_road_bank`

## Requirements
- R1: After reset, addrValid and done are 0 and dataOut is 0. The threshold is 6 and relaxed mode is off.
- R2: Opcode 1 (write) stores dataBus into layer planeSel of pattern addrIn. Opcode 7 (read) shows that stored word on dataOut after the next clock edge.
- R3: Opcode 2 (hit) sets the flag for layer planeSel in every pattern whose stored word for that layer equals dataBus. A flag stays set until the next clear. A hit with planeSel 6 or 7 sets no flag.
- R4: Opcode 4 (end of event) freezes every pattern whose matched-layer count is at least the threshold into the report set. After that edge, either addrValid or done is 1.
- R5: While the report set is not empty, addrOut shows its lowest pattern index. Opcode 6 (pop) removes that entry, so addresses appear in strictly ascending order.
- R6: done is 1 when an end of event has been taken since the last clear and the report set is empty. done and addrValid are never 1 together.
- R7: Opcode 5 (set threshold) loads dataBus[2:0] as the threshold only when that value is in the range 1 to 6; other values leave the threshold unchanged. The same command sets relaxed mode to dataBus[3].
- R8: In relaxed mode, a pattern qualifies if and only if its layer-5 flag is set and at least 4 of its layer 0 to 4 flags are set. The threshold is then ignored.
- R9: Opcode 3 (clear) clears all match flags, the report set and done in one cycle. Stored pattern words are left unchanged.
- R10: Hits taken during readout do not change the frozen report set or addrOut.
- R11: Opcode 0 and opcodes 8 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 4 | Command for this cycle |
| planeSel | input | 3 | Layer index for write, read and hit |
| dataBus | input | 12 | Hit word, write data, or threshold/mode field |
| addrIn | input | 7 | Pattern index for write and read |
| addrOut | output | 7 | Lowest pending reported pattern index |
| addrValid | output | 1 | A reported pattern is pending |
| dataOut | output | 12 | Word returned by a read |
| done | output | 1 | Readout finished, nothing left to report |

## Verification
The bank is filled so that every pattern and layer word is unique. Three patterns are then rewritten to share one set of words. A full six-layer event must report all three sharing patterns in ascending order. This separates a parallel match across all patterns from a match that stops at the first hit. A pattern with only five layers present is rejected at the default threshold and accepted at threshold 5. Out-of-range threshold values must leave the threshold as it was. Relaxed-mode events contrast three cases:
- four silicon layers plus the last layer, which qualifies;
- five silicon layers without the last layer, which does not;
- three silicon layers plus the last layer, which does not.

Hits on the wrong layer or on plane codes 6 and 7 must match nothing. Late hits and idle opcodes during readout must leave the report list unchanged. A clear in the middle of readout must empty it.

// File: rtl/road_pkg.sv
package road_pkg;
  localparam int THR_W = 3;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_WRITE  = 4'd1,
    OP_HIT    = 4'd2,
    OP_CLEAR  = 4'd3,
    OP_END    = 4'd4,
    OP_THRESH = 4'd5,
    OP_POP    = 4'd6,
    OP_READ   = 4'd7
  } opcode_e;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic             hitEn;
    logic             clrEvt;
    logic             endEvt;
    logic             popEn;
    logic [THR_W-1:0] thr;
    logic             relaxed;
  } strobe_t;
endpackage

// File: rtl/road_ctrl.sv
module road_ctrl
  import road_pkg::*;
#(
  parameter int NUM_LAYERS = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] opCode,
  input  logic [3:0] modeField,
  input  logic       anyFired,
  output strobe_t    strb,
  output logic       done
);
  logic [THR_W-1:0] thrQ;
  logic             relaxedQ;
  logic             readMode;
  logic             thrOk;

  assign thrOk = (modeField[THR_W-1:0] >= THR_W'(1)) &&
                 (modeField[THR_W-1:0] <= THR_W'(NUM_LAYERS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrQ     <= THR_W'(NUM_LAYERS);
      relaxedQ <= 1'b0;
      readMode <= 1'b0;
    end else begin
      if (opCode == OP_THRESH) begin
        relaxedQ <= modeField[3];
        if (thrOk) thrQ <= modeField[THR_W-1:0];
      end
      if (opCode == OP_CLEAR)    readMode <= 1'b0;
      else if (opCode == OP_END) readMode <= 1'b1;
    end
  end

  always_comb begin
    strb.wrEn    = (opCode == OP_WRITE);
    strb.rdEn    = (opCode == OP_READ);
    strb.hitEn   = (opCode == OP_HIT);
    strb.clrEvt  = (opCode == OP_CLEAR);
    strb.endEvt  = (opCode == OP_END);
    strb.popEn   = (opCode == OP_POP);
    strb.thr     = thrQ;
    strb.relaxed = relaxedQ;
  end

  assign done = readMode && !anyFired;
endmodule

// File: rtl/road_datapath.sv
module road_datapath
  import road_pkg::*;
#(
  parameter int NUM_PAT    = 128,
  parameter int NUM_LAYERS = 6,
  parameter int WORD_W     = 12,
  parameter int PLANE_W    = 3,
  parameter int ADDR_W     = $clog2(NUM_PAT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [PLANE_W-1:0] planeSel,
  input  logic [WORD_W-1:0]  dataBus,
  input  logic [ADDR_W-1:0]  addrIn,
  output logic [ADDR_W-1:0]  addrOut,
  output logic               addrValid,
  output logic [WORD_W-1:0]  dataOut,
  output logic               anyFired
);
  localparam int SI_LAYERS = NUM_LAYERS - 1;
  localparam int SI_NEED   = SI_LAYERS - 1;

  logic [WORD_W-1:0]     bank [NUM_PAT][NUM_LAYERS];
  logic [NUM_LAYERS-1:0] match [NUM_PAT];
  logic [NUM_PAT-1:0]    qual;
  logic [NUM_PAT-1:0]    fired;
  logic [NUM_PAT-1:0]    lowBit;
  logic                  planeOk;

  assign planeOk = (planeSel < PLANE_W'(NUM_LAYERS));

  always_ff @(posedge clk) begin
    if (strb.wrEn && planeOk) bank[addrIn][planeSel] <= dataBus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     dataOut <= '0;
    else if (strb.rdEn && planeOk) dataOut <= bank[addrIn][planeSel];
  end

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    logic [THR_W-1:0] allCnt;
    logic [THR_W-1:0] siCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        match[p] <= '0;
      else if (strb.clrEvt)
        match[p] <= '0;
      else if (strb.hitEn && planeOk && (bank[p][planeSel] == dataBus))
        match[p][planeSel] <= 1'b1;
    end

    always_comb begin
      allCnt  = THR_W'($countones(match[p]));
      siCnt   = THR_W'($countones(match[p][SI_LAYERS-1:0]));
      qual[p] = strb.relaxed ? (match[p][NUM_LAYERS-1] && (siCnt >= THR_W'(SI_NEED)))
                             : (allCnt >= strb.thr);
    end
  end

  assign lowBit = fired & (~fired + NUM_PAT'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      fired <= '0;
    else if (strb.clrEvt)           fired <= '0;
    else if (strb.endEvt)           fired <= qual;
    else if (strb.popEn && anyFired) fired <= fired & ~lowBit;
  end

  always_comb begin
    addrOut = '0;
    for (int i = NUM_PAT - 1; i >= 0; i--) begin
      if (fired[i]) addrOut = ADDR_W'(i);
    end
  end

  assign anyFired  = |fired;
  assign addrValid = anyFired;
endmodule

// File: rtl/assoc_road_bank.sv
module assoc_road_bank
  import road_pkg::*;
#(
  parameter int NUM_PAT    = 128,
  parameter int NUM_LAYERS = 6,
  parameter int WORD_W     = 12,
  parameter int PLANE_W    = 3,
  parameter int ADDR_W     = $clog2(NUM_PAT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         opCode,
  input  logic [PLANE_W-1:0] planeSel,
  input  logic [WORD_W-1:0]  dataBus,
  input  logic [ADDR_W-1:0]  addrIn,
  output logic [ADDR_W-1:0]  addrOut,
  output logic               addrValid,
  output logic [WORD_W-1:0]  dataOut,
  output logic               done
);
  strobe_t strb;
  logic    anyFired;

  road_ctrl #(.NUM_LAYERS(NUM_LAYERS)) i_ctrl (
    .clk(clk), .rstN(rstN), .opCode(opCode), .modeField(dataBus[3:0]),
    .anyFired(anyFired), .strb(strb), .done(done)
  );

  road_datapath #(
    .NUM_PAT(NUM_PAT), .NUM_LAYERS(NUM_LAYERS), .WORD_W(WORD_W),
    .PLANE_W(PLANE_W), .ADDR_W(ADDR_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .planeSel(planeSel),
    .dataBus(dataBus), .addrIn(addrIn), .addrOut(addrOut),
    .addrValid(addrValid), .dataOut(dataOut), .anyFired(anyFired)
  );
endmodule

// File: rtl/road_bank_chk.sv
module road_bank_chk #(
  parameter int ADDR_W     = 7,
  parameter int NUM_LAYERS = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        opCode,
  input logic [ADDR_W-1:0] addrOut,
  input logic              addrValid,
  input logic              done,
  input logic [2:0]        thr
);
  p_done_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !addrValid);

  p_end_result_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd4) |=> (addrValid || done));

  p_ascending_r5: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && opCode == 4'd6) |=> (!addrValid || (addrOut > $past(addrOut))));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd3) |=> (!addrValid && !done));

  p_late_hit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && opCode == 4'd2) |=> (addrValid && $stable(addrOut)));

  p_idle_op_r11: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && (opCode == 4'd0 || opCode >= 4'd8)) |=> (addrValid && $stable(addrOut)));

  always @(posedge clk) begin
    if (rstN) begin
      p_thr_range_r7: assert (thr >= 3'd1 && 32'(thr) <= NUM_LAYERS);
    end
  end
endmodule

bind assoc_road_bank road_bank_chk #(.ADDR_W(ADDR_W), .NUM_LAYERS(NUM_LAYERS)) i_chk (
  .clk(clk), .rstN(rstN), .opCode(opCode), .addrOut(addrOut),
  .addrValid(addrValid), .done(done), .thr(strb.thr)
);

// File: tb/test_assoc_road_bank.sv
module test_assoc_road_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [2:0]  planeSel = 3'd0;
  logic [11:0] dataBus = 12'd0;
  logic [6:0]  addrIn = 7'd0;
  logic [6:0]  addrOut;
  logic        addrValid;
  logic [11:0] dataOut;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assoc_road_bank i_assoc_road_bank (
    .clk(clk), .rstN(rstN), .opCode(opCode), .planeSel(planeSel),
    .dataBus(dataBus), .addrIn(addrIn), .addrOut(addrOut),
    .addrValid(addrValid), .dataOut(dataOut), .done(done)
  );

  function automatic logic [11:0] wordOf(int p, int l);
    return 12'(p * 8 + l);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic op(logic [3:0] o, logic [2:0] pl, logic [11:0] d, logic [6:0] a);
    @(negedge clk);
    opCode = o; planeSel = pl; dataBus = d; addrIn = a;
    @(negedge clk);
    opCode = 4'd0;
  endtask

  task automatic hitAll(int p, int firstL, int lastL);
    for (int l = firstL; l <= lastL; l++) op(4'd2, 3'(l), wordOf(p, l), 7'd0);
  endtask

  task automatic drain(string tag, int n, int e0, int e1, int e2, int e3);
    int e [4];
    e = '{e0, e1, e2, e3};
    for (int i = 0; i < n; i++) begin
      chk(addrValid && (addrOut == 7'(e[i])), tag, addrValid ? int'(addrOut) : -1, e[i]);
      op(4'd6, 3'd0, 12'd0, 7'd0);
    end
    chk(done && !addrValid, {tag, " done"}, {30'd0, done, addrValid}, 2);
  endtask

  task automatic t_reset;
    chk(!addrValid && !done, "R1 outputs idle", {30'd0, addrValid, done}, 0);
    chk(dataOut == 12'd0, "R1 dataOut", dataOut, 0);
  endtask

  task automatic t_load;
    for (int p = 0; p < 128; p++)
      for (int l = 0; l < 6; l++) op(4'd1, 3'(l), wordOf(p, l), 7'(p));
    for (int l = 0; l < 6; l++) begin
      op(4'd1, 3'(l), wordOf(3, l), 7'd10);
      op(4'd1, 3'(l), wordOf(3, l), 7'd77);
    end
    op(4'd7, 3'd2, 12'd0, 7'd77);
    chk(dataOut == wordOf(3, 2), "R2 read back overwritten", dataOut, wordOf(3, 2));
    op(4'd7, 3'd4, 12'd0, 7'd5);
    chk(dataOut == wordOf(5, 4), "R2 read back loaded", dataOut, wordOf(5, 4));
  endtask

  task automatic t_full_match;
    op(4'd3, 3'd0, 12'd0, 7'd0);
    hitAll(3, 0, 5);
    hitAll(20, 0, 4);
    op(4'd4, 3'd0, 12'd0, 7'd0);
    chk(addrValid && addrOut == 7'd3, "R4 R1 default threshold first", addrOut, 3);
    op(4'd2, 3'd5, wordOf(20, 5), 7'd0);
    chk(addrValid && addrOut == 7'd3, "R10 late hit", addrOut, 3);
    op(4'd9, 3'd0, 12'd0, 7'd0);
    op(4'd0, 3'd0, 12'd0, 7'd0);
    chk(addrValid && addrOut == 7'd3, "R11 idle opcodes", addrOut, 3);
    drain("R5 R3 full match list", 3, 3, 10, 77, 0);
  endtask

  task automatic t_threshold;
    op(4'd5, 3'd0, 12'd5, 7'd0);
    op(4'd3, 3'd0, 12'd0, 7'd0);
    hitAll(3, 0, 5);
    hitAll(20, 0, 4);
    op(4'd4, 3'd0, 12'd0, 7'd0);
    drain("R7 threshold 5 list", 4, 3, 10, 20, 77);
    op(4'd5, 3'd0, 12'd6, 7'd0);
    op(4'd5, 3'd0, 12'd0, 7'd0);
    op(4'd5, 3'd0, 12'd7, 7'd0);
    op(4'd3, 3'd0, 12'd0, 7'd0);
    hitAll(20, 0, 4);
    op(4'd4, 3'd0, 12'd0, 7'd0);
    drain("R7 bad thresholds ignored", 0, 0, 0, 0, 0);
  endtask

  task automatic t_relaxed;
    op(4'd5, 3'd0, 12'hE, 7'd0);
    op(4'd3, 3'd0, 12'd0, 7'd0);
    hitAll(30, 0, 3);
    hitAll(30, 5, 5);
    hitAll(31, 0, 4);
    hitAll(32, 0, 2);
    hitAll(32, 5, 5);
    op(4'd4, 3'd0, 12'd0, 7'd0);
    drain("R8 relaxed list", 1, 30, 0, 0, 0);
    op(4'd5, 3'd0, 12'h1, 7'd0);
  endtask

  task automatic t_planes;
    op(4'd3, 3'd0, 12'd0, 7'd0);
    op(4'd2, 3'd6, wordOf(40, 0), 7'd0);
    op(4'd2, 3'd7, wordOf(40, 0), 7'd0);
    op(4'd2, 3'd1, wordOf(40, 0), 7'd0);
    op(4'd2, 3'd2, wordOf(41, 2), 7'd0);
    op(4'd4, 3'd0, 12'd0, 7'd0);
    drain("R3 plane steering", 1, 41, 0, 0, 0);
  endtask

  task automatic t_clear;
    op(4'd3, 3'd0, 12'd0, 7'd0);
    op(4'd2, 3'd2, wordOf(41, 2), 7'd0);
    op(4'd4, 3'd0, 12'd0, 7'd0);
    chk(addrValid && addrOut == 7'd41, "R9 before clear", addrOut, 41);
    op(4'd3, 3'd0, 12'd0, 7'd0);
    chk(!addrValid && !done, "R9 clear empties", {30'd0, addrValid, done}, 0);
    op(4'd4, 3'd0, 12'd0, 7'd0);
    chk(done && !addrValid, "R9 R6 flags cleared", {30'd0, done, addrValid}, 2);
    op(4'd7, 3'd2, 12'd0, 7'd41);
    chk(dataOut == wordOf(41, 2), "R9 storage kept", dataOut, wordOf(41, 2));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_full_match();
    t_threshold();
    t_relaxed();
    t_planes();
    t_clear();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule